// File: doc/BRIEF.md
# Read-Only Converter Result Target

This block is the digital control core of a converter whose results are only ever read over an I2C bus. It steps through three phases: converting, sleeping with a finished result, and shifting that result out to a bus controller. The conversion itself sits outside the block. The block asks for a conversion with a one-cycle start strobe. The converter answers with a one-cycle done strobe and a 16-bit result word.

On the bus side, the block is a target with a fixed address. SCL is an input. SDA is open-drain, modelled as an input and an output enable that pulls the line low. Both lines are oversampled by the system clock through synchronisers. Start and stop conditions are found as SDA edges while SCL is high.

After a valid read, the next conversion starts on a stop condition. It also starts once all 16 result bits have left the block, whichever comes first. Each read therefore returns exactly one fresh conversion.

Top module: `conv_read_target`

## Requirements
- R1: While reset is low, and for POR_CYCLES system clocks after it is released, `sda_oe` and `conv_start` stay 0. Then `conv_start` pulses high for exactly one clock, and the block is converting.
- R2: While converting, an address byte is not acknowledged, so SDA stays released during the ninth clock. A stop condition in this phase starts no conversion.
- R3: A `conv_done` pulse while converting captures `conv_result` and moves the block to sleep. A `conv_done` pulse at any other time leaves the held result unchanged.
- R4: In sleep, the address byte 0010100 followed by a R/W bit of 1 (read) is acknowledged. The block pulls SDA low for the whole ninth clock and enters data output.
- R5: An address byte with R/W = 0, or with any other 7-bit address, is not acknowledged. The phase and the held result stay as they were.
- R6: The result leaves as two bytes, most significant bit first, so the sign bit comes first. The bits equal the last captured result. SDA changes only after SCL falling edges and holds steady while SCL is high.
- R7: The block releases SDA during the controller's acknowledge slot after each data byte.
- R8: On the SCL fall that ends the 16th data bit, `conv_start` pulses once with no stop condition needed. A later stop adds no further pulse.
- R9: A stop condition during data output, before all 16 bits are sent, starts a conversion.
- R10: A controller NACK after the first data byte returns the block to sleep. The result is kept, and no conversion starts, not even on the stop that follows.
- R11: A repeated start during data output aborts the transfer without starting a conversion. The address byte that follows is judged again, and a matching read acknowledges and returns the same result.
- R12: The address is judged on the phase held before the clock edge that samples the eighth address bit. A `conv_done` pulse on that same edge still captures its result, but the byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| conv_start | output | 1 | One-cycle request for a new conversion |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_result | input | RES_W | Result word, valid with `conv_done` |

## Verification
The critical overlap is a converter done strobe landing on the same system clock edge that samples the last bit of an address byte. One question then decides both whether the byte is acknowledged and whether the result is taken: which phase is in force at that edge. The bench drives SCL high and counts the synchroniser delay. It then places the `conv_done` pulse so that the design registers it on the very edge that acts on that SCL rise. The outcome is correct when the acknowledge slot shows a NACK and a following read is acknowledged and returns the word carried by that pulse.

// File: rtl/conv_read_pkg.sv
package conv_read_pkg;

  // Converter-side phase
  typedef enum logic [1:0] {
    PH_POR   = 2'd0,
    PH_CONV  = 2'd1,
    PH_SLEEP = 2'd2,
    PH_OUT   = 2'd3
  } phase_e;

  // Bus-side link state
  typedef enum logic [2:0] {
    LK_IDLE = 3'd0,
    LK_ADDR = 3'd1,
    LK_AACK = 3'd2,
    LK_DATA = 3'd3,
    LK_DACK = 3'd4
  } link_e;

endpackage

// File: rtl/crt_sync.sv
module crt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  // Idle bus is high, so every stage resets to 1 and no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/crt_seq.sv
module crt_seq
  import conv_read_pkg::*;
#(
  parameter int RES_W      = 16,
  parameter int POR_CYCLES = 62500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             read_go,
  input  logic             all_sent,
  input  logic             ctl_nack,
  input  logic             start_c,
  input  logic             stop_c,
  output phase_e           phase_q,
  output logic [RES_W-1:0] res_q,
  output logic             conv_start
);

  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

  phase_e           phase_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;
  logic             cap_en;
  logic             start_n;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    cap_en  = 1'b0;
    start_n = 1'b0;
    case (phase_q)
      PH_POR: begin
        if (cnt_q == CNT_LAST) begin
          phase_n = PH_CONV;
          start_n = 1'b1;
        end else begin
          cnt_en = 1'b1;
          cnt_n  = cnt_q + 1'b1;
        end
      end
      PH_CONV: begin
        if (conv_done) begin
          cap_en  = 1'b1;
          phase_n = PH_SLEEP;
        end
      end
      PH_SLEEP: begin
        if (read_go) phase_n = PH_OUT;
      end
      PH_OUT: begin
        if (all_sent || stop_c) begin
          phase_n = PH_CONV;
          start_n = 1'b1;
        end else if (ctl_nack || start_c) begin
          phase_n = PH_SLEEP;
        end
      end
      default: phase_n = PH_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_POR;
      cnt_q      <= '0;
      res_q      <= '0;
      conv_start <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      conv_start <= start_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (cap_en) res_q <= conv_result;
    end
  end

endmodule

// File: rtl/crt_link.sv
module crt_link
  import conv_read_pkg::*;
#(
  parameter int          RES_W    = 16,
  parameter logic [6:0]  TGT_ADDR = 7'b0010100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_c,
  input  logic             stop_c,
  input  phase_e           phase_q,
  input  logic [RES_W-1:0] res_q,
  output logic             sda_oe,
  output logic             read_go,
  output logic             all_sent,
  output logic             ctl_nack,
  output link_e            link_q
);

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
  localparam logic [7:0] RD_BYTE = {TGT_ADDR, 1'b1};

  link_e            link_n;
  logic [7:0]       sh_q, sh_n;
  logic [3:0]       cnt_q, cnt_n;
  logic             ok_q, ok_n;
  logic             mack_q, mack_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [7:0]       sh_in;

  assign sh_in = {sh_q[6:0], sda_s};

  always_comb begin
    link_n   = link_q;
    sh_n     = sh_q;
    cnt_n    = cnt_q;
    ok_n     = ok_q;
    mack_n   = mack_q;
    idx_n    = idx_q;
    read_go  = 1'b0;
    all_sent = 1'b0;
    ctl_nack = 1'b0;
    if (start_c) begin
      link_n = LK_ADDR;
      cnt_n  = 4'd0;
      ok_n   = 1'b0;
    end else if (stop_c) begin
      link_n = LK_IDLE;
    end else begin
      case (link_q)
        LK_ADDR: begin
          if (scl_rise && (cnt_q < 4'd8)) begin
            sh_n  = sh_in;
            cnt_n = cnt_q + 4'd1;
            // decision taken on the phase held before this edge
            if (cnt_q == 4'd7) ok_n = (sh_in == RD_BYTE) && (phase_q == PH_SLEEP);
          end else if (scl_fall && (cnt_q == 4'd8)) begin
            if (ok_q) begin
              link_n  = LK_AACK;
              read_go = 1'b1;
            end else begin
              link_n = LK_IDLE;
            end
          end
        end
        LK_AACK: begin
          if (scl_fall) begin
            link_n = LK_DATA;
            idx_n  = IDX_TOP;
          end
        end
        LK_DATA: begin
          if (scl_fall) begin
            if (idx_q == '0) begin
              all_sent = 1'b1;
              link_n   = LK_IDLE;
            end else if (idx_q[2:0] == 3'd0) begin
              link_n = LK_DACK;
            end else begin
              idx_n = idx_q - 1'b1;
            end
          end
        end
        LK_DACK: begin
          if (scl_rise) begin
            mack_n = sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              ctl_nack = 1'b1;
              link_n   = LK_IDLE;
            end else begin
              link_n = LK_DATA;
              idx_n  = idx_q - 1'b1;
            end
          end
        end
        default: link_n = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= LK_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
      mack_q <= 1'b1;
      idx_q  <= '0;
    end else begin
      link_q <= link_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      ok_q   <= ok_n;
      mack_q <= mack_n;
      idx_q  <= idx_n;
    end
  end

  assign sda_oe = (link_q == LK_AACK) || ((link_q == LK_DATA) && !res_q[idx_q]);

endmodule

// File: rtl/conv_read_target.sv
module conv_read_target
  import conv_read_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'b0010100,
  parameter int         RES_W       = 16,
  parameter int         POR_CYCLES  = 62500,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);

  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic             read_go, all_sent, ctl_nack;
  phase_e           phase_q;
  link_e            link_q;
  logic [RES_W-1:0] res_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  crt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  crt_seq #(.RES_W(RES_W), .POR_CYCLES(POR_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .read_go     (read_go),
    .all_sent    (all_sent),
    .ctl_nack    (ctl_nack),
    .start_c     (start_c),
    .stop_c      (stop_c),
    .phase_q     (phase_q),
    .res_q       (res_q),
    .conv_start  (conv_start)
  );

  crt_link #(.RES_W(RES_W), .TGT_ADDR(TGT_ADDR)) u_link (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .phase_q  (phase_q),
    .res_q    (res_q),
    .sda_oe   (sda_oe),
    .read_go  (read_go),
    .all_sent (all_sent),
    .ctl_nack (ctl_nack),
    .link_q   (link_q)
  );

endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import conv_read_pkg::*;
#(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             conv_start,
  input logic             conv_done,
  input phase_e           phase_q,
  input logic [RES_W-1:0] res_q,
  input link_e            link_q
);

  p_quiet_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_POR) |-> (!sda_oe && !conv_start));

  p_no_ack_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV) |-> !sda_oe);

  p_done_to_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && conv_done) |=> (phase_q == PH_SLEEP));

  p_hold_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SLEEP) |=> $stable(res_q));

  p_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_no_start_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SLEEP) |-> !conv_start);

  p_out_has_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OUT) |-> (link_q != LK_IDLE && link_q != LK_ADDR));

endmodule

bind conv_read_target crt_checker #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .scl_s      (scl_s),
  .sda_oe     (sda_oe),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .phase_q    (phase_q),
  .res_q      (res_q),
  .link_q     (link_q)
);

// File: tb/sim_conv_read_target.sv
`timescale 1ns/1ps
module sim_conv_read_target;

  localparam int Q   = 6;
  localparam int POR = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl;
  logic        m_sda;
  logic        conv_done;
  logic [15:0] conv_result;
  logic        sda_oe;
  logic        conv_start;
  logic        sda_line;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  conv_read_target #(.POR_CYCLES(POR)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe      (sda_oe),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .conv_result (conv_result)
  );

  typedef struct {
    string req;
    int    val;
  } item_t;

  item_t exp_q[$];
  int    obs_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    n_starts = 0;
  bit    ended = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input string req, input int val);
    item_t it;
    it.req = req;
    it.val = val;
    exp_q.push_back(it);
  endtask

  // monitor: compares produced items against the scoreboard queue
  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      int got;
      got = obs_q.pop_front();
      if (exp_q.size() == 0) begin
        check("scoreboard", "unexpected item", got, -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.req, "bus item", got, it.val);
      end
    end
  end

  always @(negedge clk) if (conv_start) n_starts++;

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all R): actual=timeout expected=completion");
    finish_run();
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; wait_clks(Q);
    m_sda = 1'b0; wait_clks(Q);
    scl = 1'b0; wait_clks(Q);
  endtask

  task automatic bus_restart();
    m_sda = 1'b1; wait_clks(Q);
    scl = 1'b1; wait_clks(Q);
    m_sda = 1'b0; wait_clks(Q);
    scl = 1'b0; wait_clks(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clks(Q);
    scl = 1'b1; wait_clks(Q);
    m_sda = 1'b1; wait_clks(Q);
  endtask

  task automatic clk_bit(input bit b, output bit r, output bit oe);
    m_sda = b; wait_clks(Q);
    scl = 1'b1; wait_clks(Q);
    r = sda_line; oe = sda_oe;
    wait_clks(Q);
    scl = 1'b0; wait_clks(Q);
  endtask

  task automatic send_addr(input logic [7:0] b, output bit ack);
    bit r, oe;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r, oe);
    clk_bit(1'b1, r, oe);
    ack = !r;
  endtask

  // last address bit with a done strobe on the edge that samples it
  task automatic send_addr_coinc(input logic [7:0] b, input logic [15:0] v, output bit ack);
    bit r, oe;
    for (int i = 7; i >= 1; i--) clk_bit(b[i], r, oe);
    m_sda = b[0]; wait_clks(Q);
    scl = 1'b1;
    wait_clks(2);
    conv_done = 1'b1; conv_result = v;
    wait_clks(1);
    conv_done = 1'b0;
    wait_clks(Q - 3);
    wait_clks(Q);
    scl = 1'b0; wait_clks(Q);
    clk_bit(1'b1, r, oe);
    ack = !r;
  endtask

  task automatic rd_byte(input bit m_ack, output int val, output bit slot_oe);
    bit r, oe;
    val = 0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r, oe);
      val = (val << 1) | int'(r);
    end
    clk_bit(m_ack ? 1'b0 : 1'b1, r, slot_oe);
  endtask

  task automatic finish_conv(input logic [15:0] v);
    conv_result = v; conv_done = 1'b1;
    wait_clks(1);
    conv_done = 1'b0;
    wait_clks(4);
  endtask

  task automatic read_two(input string req, input logic [15:0] v, input int starts_after);
    int  hi, lo;
    bit  oe1, oe2;
    expect_item(req, int'(v[15:8]));
    rd_byte(1'b1, hi, oe1);
    obs_q.push_back(hi);
    check("R7", "oe in ack slot of byte 1", int'(oe1), 0);
    expect_item(req, int'(v[7:0]));
    rd_byte(1'b0, lo, oe2);
    obs_q.push_back(lo);
    check("R7", "oe in ack slot of byte 2", int'(oe2), 0);
    check("R8", "starts after 16th bit", n_starts, starts_after);
  endtask

  task automatic full_read(input string req, input logic [15:0] v, input int starts_after);
    bit ack;
    bus_start();
    expect_item("R4", 1);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    read_two(req, v, starts_after);
    bus_stop();
    wait_clks(6);
    check("R8", "no extra start on stop", n_starts, starts_after);
  endtask

  initial begin
    bit ack;
    int hi;
    bit oe;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; conv_done = 1'b0; conv_result = '0;
    wait_clks(5);
    check("R1", "oe in reset", int'(sda_oe), 0);
    check("R1", "conv_start in reset", int'(conv_start), 0);
    rst_n = 1'b1;
    wait_clks(POR - 8);
    check("R1", "no start before hold", n_starts, 0);
    wait_clks(30);
    check("R1", "one start after hold", n_starts, 1);

    // R2: converting, so no acknowledge
    bus_start();
    expect_item("R2", 0);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    bus_stop();
    wait_clks(6);
    check("R2", "stop while converting", n_starts, 1);

    // R4 / R6 / R8: plain read
    finish_conv(16'hA5C3);
    full_read("R6", 16'hA5C3, 2);

    // R3: stray done strobe in sleep is ignored
    finish_conv(16'h1234);
    finish_conv(16'hFFFF);
    full_read("R3", 16'h1234, 3);

    // R5: write bit and foreign address
    finish_conv(16'h8001);
    bus_start();
    expect_item("R5", 0);
    send_addr(8'h28, ack);
    obs_q.push_back(int'(ack));
    bus_stop();
    bus_start();
    expect_item("R5", 0);
    send_addr(8'h2B, ack);
    obs_q.push_back(int'(ack));
    bus_stop();
    wait_clks(6);
    check("R5", "no start after rejected bytes", n_starts, 3);
    full_read("R5", 16'h8001, 4);

    // R10: controller NACK after first byte
    finish_conv(16'h4E00);
    bus_start();
    expect_item("R10", 1);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    expect_item("R10", 16'h4E);
    rd_byte(1'b0, hi, oe);
    obs_q.push_back(hi);
    check("R7", "oe in NACK slot", int'(oe), 0);
    bus_stop();
    wait_clks(6);
    check("R10", "no start after NACK and stop", n_starts, 4);
    full_read("R10", 16'h4E00, 5);

    // R11: repeated start aborts the output
    finish_conv(16'h9F37);
    bus_start();
    expect_item("R11", 1);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    bus_restart();
    check("R11", "no start on repeated start", n_starts, 5);
    expect_item("R11", 1);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    read_two("R11", 16'h9F37, 6);
    bus_stop();
    wait_clks(6);

    // R9: stop right after the address acknowledge
    finish_conv(16'hC0DE);
    bus_start();
    expect_item("R9", 1);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    bus_stop();
    wait_clks(6);
    check("R9", "stop during output starts conversion", n_starts, 7);
    bus_start();
    expect_item("R2", 0);
    send_addr(8'h29, ack);
    obs_q.push_back(int'(ack));
    bus_stop();
    finish_conv(16'h0F0F);
    full_read("R6", 16'h0F0F, 8);

    // R12: done strobe on the edge sampling the eighth address bit
    bus_start();
    expect_item("R12", 0);
    send_addr_coinc(8'h29, 16'h6A5B, ack);
    obs_q.push_back(int'(ack));
    bus_stop();
    wait_clks(6);
    full_read("R12", 16'h6A5B, 9);

    wait_clks(10);
    check("scoreboard", "items left unmatched", exp_q.size(), 0);
    finish_run();
  end

endmodule